// File: doc/BRIEF.md
# Cable-Test Reflectometry Sequencer

This block runs one cable-diagnostic pass for a single-pair line. Software programs a silence interval before the test, a transmit duration in microseconds, a silence interval after the test and a drive level. It then sets the start bit. The sequencer holds the line quiet for the first interval and enables the modulated test transmitter for the programmed time. It holds the line quiet for the second interval and then falls into forced-link mode. Forced-link mode lasts until the next start.

An external correlation detector reports reflections as a valid strobe with a sign and a 10-bit location. The sequencer latches the result into a status register while the transmit and trailing-silence phases run. If link-partner energy shows up during the leading silence, the run aborts with both done and fail set. Timing comes from a microsecond tick, produced by a prescaler on the system clock. A millisecond is `US_PER_MS` ticks and a microsecond is `TICK_DIV` clocks.

Top module: `reflo_seq`

## Requirements
- R1: After reset the registers read as follows: control (address 0) reads 0, setup (address 1) reads 0, duration (address 2) reads 16000, taps (address 3) reads 0x2404 and result (address 4) reads 0. The outputs txEnable, quietHold and forcedLink are low, tapStart is 4 and tapEnd is 36.
- R2: Writing control bit 15 while no run is active starts a run. Bit 15 reads 1 until the run begins on the following clock and reads 0 from then on. Done (control bit 1) and fail (control bit 0) are cleared when the run begins.
- R3: The leading silence length comes from setup bits 1:0, coded 0/1/2/3 = 0/10/100/1000 ms. A phase of N microseconds lasts N·TICK_DIV clocks, or one clock when N is 0. During the phase quietHold is high and txEnable is low.
- R4: The transmit phase follows the leading silence. txEnable is high for duration·TICK_DIV clocks, or one clock when the duration is 0. While txEnable is high, txAmpHigh equals setup bit 12.
- R5: The trailing silence follows transmit. Its length comes from setup bits 3:2 with the same coding as R3, and quietHold is high throughout.
- R6: After the trailing silence, forcedLink goes high and control reads done=1, fail=0. This state holds until the next start.
- R7: lineEnergy high on any clock of the leading silence, including its last clock, aborts the run. No transmit follows, control reads done=1 and fail=1, and forcedLink stays low. lineEnergy has no effect in other phases.
- R8: A peakValid during transmit or trailing silence loads the result register: bit 11 is set to 1, bit 10 takes peakSign and bits 9:0 take peakLoc. The latest strobe wins. peakValid outside those phases is ignored, and the register clears when a run begins.
- R9: A start write while a run is active is ignored. The run keeps its timing and no second run follows.
- R10: The taps register (address 3) holds the start index in bits 6:0 and the end index in bits 14:8. Both drive the tapStart and tapEnd outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data (combinational) |
| lineEnergy | input | 1 | Link-partner energy seen on the line |
| peakValid | input | 1 | Detector reports a reflection peak |
| peakSign | input | 1 | Polarity of the reported peak |
| peakLoc | input | 10 | Location of the reported peak |
| txEnable | output | 1 | Modulated test transmission active |
| txAmpHigh | output | 1 | Higher drive level selected during transmit |
| quietHold | output | 1 | Line held silent (leading or trailing interval) |
| forcedLink | output | 1 | Sequence finished, forced-link mode |
| tapStart | output | 7 | Detector start tap index |
| tapEnd | output | 7 | Detector end tap index |

## Verification
There are two collisions to exercise. The first is link-partner energy arriving on the very clock the leading silence ends. The bench counts the leading-silence clocks and raises lineEnergy exactly on the last one, then requires an abort with no transmit clock at all. The second is a detector peak arriving on the single clock of a zero-length trailing silence. Here the capture must land even though the phase change to forced-link happens at the same edge, and a peak on the next clock must be dropped.

// File: rtl/reflo_pkg.sv
package reflo_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_TX   = 3'd2,
    ST_POST = 3'd3,
    ST_LINK = 3'd4
  } seqState_e;

  // strobes from the control FSM into the datapath
  typedef struct packed {
    logic loadPre;
    logic loadTx;
    logic loadPost;
    logic clrRun;
    logic capWin;
    logic finOk;
    logic finFail;
  } seqStrobe_t;

  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_CFG  = 3'd1;
  localparam logic [2:0] ADDR_DUR  = 3'd2;
  localparam logic [2:0] ADDR_TAP  = 3'd3;
  localparam logic [2:0] ADDR_STAT = 3'd4;

  localparam int TAP_W = 7;
  localparam int LOC_W = 10;
  localparam logic [15:0] DUR_RST   = 16'd16000;
  localparam logic [6:0]  TAP_S_RST = 7'd4;
  localparam logic [6:0]  TAP_E_RST = 7'd36;

  function automatic int unsigned codeToMs(input logic [1:0] code);
    case (code)
      2'd0:    codeToMs = 0;
      2'd1:    codeToMs = 10;
      2'd2:    codeToMs = 100;
      default: codeToMs = 1000;
    endcase
  endfunction

endpackage

// File: rtl/reflo_ctrl.sv
module reflo_ctrl
  import reflo_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       phaseEnd,
  input  logic       lineEnergy,
  output seqState_e  state,
  output seqStrobe_t strb
);

  seqState_e nextState;

  always_comb begin
    nextState = state;
    strb      = '0;
    case (state)
      ST_IDLE, ST_LINK: begin
        if (startReq) begin
          nextState    = ST_PRE;
          strb.loadPre = 1'b1;
          strb.clrRun  = 1'b1;
        end
      end
      ST_PRE: begin
        if (lineEnergy) begin
          nextState    = ST_IDLE;
          strb.finFail = 1'b1;
        end else if (phaseEnd) begin
          nextState   = ST_TX;
          strb.loadTx = 1'b1;
        end
      end
      ST_TX: begin
        strb.capWin = 1'b1;
        if (phaseEnd) begin
          nextState     = ST_POST;
          strb.loadPost = 1'b1;
        end
      end
      ST_POST: begin
        strb.capWin = 1'b1;
        if (phaseEnd) begin
          nextState  = ST_LINK;
          strb.finOk = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  // energy during leading silence always aborts, even on its last clock
  p_abort_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PRE && lineEnergy) |=> (state == ST_IDLE));

  p_link_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LINK && !startReq) |=> (state == ST_LINK));

  p_tx_entry_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TX && $past(state) != ST_TX) |-> ($past(state) == ST_PRE));

endmodule

// File: rtl/reflo_dp.sv
module reflo_dp
  import reflo_pkg::*;
#(
  parameter int unsigned TICK_DIV  = 125,
  parameter int unsigned US_PER_MS = 1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [2:0]       regAddr,
  input  logic [15:0]      regWdata,
  output logic [15:0]      regRdata,
  input  seqStrobe_t       strb,
  input  logic             running,
  input  logic             peakValid,
  input  logic             peakSign,
  input  logic [LOC_W-1:0] peakLoc,
  output logic             startReq,
  output logic             phaseEnd,
  output logic             ampSel,
  output logic [TAP_W-1:0] tapStart,
  output logic [TAP_W-1:0] tapEnd
);

  localparam int unsigned MAX_TICKS = 1000 * US_PER_MS;
  localparam int CNT_W = ($clog2(MAX_TICKS + 1) > 16) ? $clog2(MAX_TICKS + 1) : 16;
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  function automatic logic [CNT_W-1:0] silTicks(input logic [1:0] code);
    silTicks = CNT_W'(codeToMs(code) * US_PER_MS);
  endfunction

  logic             startPend, doneBit, failBit;
  logic [1:0]       preCode, postCode;
  logic [15:0]      durReg;
  logic [TAP_W-1:0] tapStartR, tapEndR;
  logic             peakHit, peakSgn;
  logic [LOC_W-1:0] peakLocR;
  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] phaseCnt;
  logic             tick, anyLoad;
  logic             wrCtrl, wrCfg, wrDur, wrTap;

  assign tick    = (preCnt == PRE_W'(TICK_DIV - 1));
  assign anyLoad = strb.loadPre | strb.loadTx | strb.loadPost;
  assign wrCtrl  = regWe && (regAddr == ADDR_CTRL);
  assign wrCfg   = regWe && (regAddr == ADDR_CFG);
  assign wrDur   = regWe && (regAddr == ADDR_DUR);
  assign wrTap   = regWe && (regAddr == ADDR_TAP);

  // setup registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCode   <= 2'd0;
      postCode  <= 2'd0;
      ampSel    <= 1'b0;
      durReg    <= DUR_RST;
      tapStartR <= TAP_S_RST;
      tapEndR   <= TAP_E_RST;
    end else begin
      if (wrCfg) begin
        preCode  <= regWdata[1:0];
        postCode <= regWdata[3:2];
        ampSel   <= regWdata[12];
      end
      if (wrDur) durReg <= regWdata;
      if (wrTap) begin
        tapStartR <= regWdata[6:0];
        tapEndR   <= regWdata[14:8];
      end
    end
  end

  // start request and run flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startPend <= 1'b0;
      doneBit   <= 1'b0;
      failBit   <= 1'b0;
    end else begin
      if (strb.clrRun)                               startPend <= 1'b0;
      else if (wrCtrl && regWdata[15] && !running)   startPend <= 1'b1;
      if (strb.clrRun) begin
        doneBit <= 1'b0;
        failBit <= 1'b0;
      end else if (strb.finFail) begin
        doneBit <= 1'b1;
        failBit <= 1'b1;
      end else if (strb.finOk) begin
        doneBit <= 1'b1;
      end
    end
  end

  // reflection result capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      peakHit  <= 1'b0;
      peakSgn  <= 1'b0;
      peakLocR <= '0;
    end else if (strb.clrRun) begin
      peakHit  <= 1'b0;
      peakSgn  <= 1'b0;
      peakLocR <= '0;
    end else if (strb.capWin && peakValid) begin
      peakHit  <= 1'b1;
      peakSgn  <= peakSign;
      peakLocR <= peakLoc;
    end
  end

  // microsecond prescaler, realigned on every phase load
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               preCnt <= '0;
    else if (anyLoad || tick) preCnt <= '0;
    else                     preCnt <= preCnt + 1'b1;
  end

  // shared phase counter in microsecond ticks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              phaseCnt <= '0;
    else if (strb.loadPre)                  phaseCnt <= silTicks(preCode);
    else if (strb.loadTx)                   phaseCnt <= CNT_W'(durReg);
    else if (strb.loadPost)                 phaseCnt <= silTicks(postCode);
    else if (tick && (phaseCnt != '0))      phaseCnt <= phaseCnt - 1'b1;
  end

  assign phaseEnd = (phaseCnt == '0) || ((phaseCnt == CNT_W'(1)) && tick);
  assign startReq = startPend;
  assign tapStart = tapStartR;
  assign tapEnd   = tapEndR;

  always_comb begin
    case (regAddr)
      ADDR_CTRL: regRdata = {startPend, 13'd0, doneBit, failBit};
      ADDR_CFG:  regRdata = {3'd0, ampSel, 8'd0, postCode, preCode};
      ADDR_DUR:  regRdata = durReg;
      ADDR_TAP:  regRdata = {1'b0, tapEndR, 1'b0, tapStartR};
      ADDR_STAT: regRdata = {4'd0, peakHit, peakSgn, peakLocR};
      default:   regRdata = 16'd0;
    endcase
  end

  p_start_self_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrRun |=> !startPend);

  p_count_no_rise_r3: assert property (@(posedge clk) disable iff (!rstN)
    !anyLoad |=> (phaseCnt <= $past(phaseCnt)));

  p_fail_sets_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.finFail |=> (doneBit && failBit));

  p_status_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.capWin && !strb.clrRun) |=> $stable({peakHit, peakSgn, peakLocR}));

  p_busy_blocks_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    (running && !startPend) |=> !startPend);

endmodule

// File: rtl/reflo_seq.sv
module reflo_seq
  import reflo_pkg::*;
#(
  parameter int unsigned TICK_DIV  = 125,
  parameter int unsigned US_PER_MS = 1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [2:0]  regAddr,
  input  logic [15:0] regWdata,
  output logic [15:0] regRdata,
  input  logic        lineEnergy,
  input  logic        peakValid,
  input  logic        peakSign,
  input  logic [9:0]  peakLoc,
  output logic        txEnable,
  output logic        txAmpHigh,
  output logic        quietHold,
  output logic        forcedLink,
  output logic [6:0]  tapStart,
  output logic [6:0]  tapEnd
);

  seqState_e  state;
  seqStrobe_t strb;
  logic       startReq, phaseEnd, ampSel, running;

  assign running    = (state == ST_PRE) || (state == ST_TX) || (state == ST_POST);
  assign txEnable   = (state == ST_TX);
  assign quietHold  = (state == ST_PRE) || (state == ST_POST);
  assign forcedLink = (state == ST_LINK);
  assign txAmpHigh  = txEnable & ampSel;

  reflo_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .phaseEnd   (phaseEnd),
    .lineEnergy (lineEnergy),
    .state      (state),
    .strb       (strb)
  );

  reflo_dp #(.TICK_DIV(TICK_DIV), .US_PER_MS(US_PER_MS)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .regWe     (regWe),
    .regAddr   (regAddr),
    .regWdata  (regWdata),
    .regRdata  (regRdata),
    .strb      (strb),
    .running   (running),
    .peakValid (peakValid),
    .peakSign  (peakSign),
    .peakLoc   (peakLoc),
    .startReq  (startReq),
    .phaseEnd  (phaseEnd),
    .ampSel    (ampSel),
    .tapStart  (tapStart),
    .tapEnd    (tapEnd)
  );

endmodule

// File: tb/reflo_seq_tb_top.sv
module reflo_seq_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [15:0] regWdata = 16'd0;
  logic [15:0] regRdata;
  logic        lineEnergy = 1'b0, peakValid = 1'b0, peakSign = 1'b0;
  logic [9:0]  peakLoc = 10'd0;
  logic        txEnable, txAmpHigh, quietHold, forcedLink;
  logic [6:0]  tapStart, tapEnd;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  reflo_seq #(.TICK_DIV(2), .US_PER_MS(3)) dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .lineEnergy(lineEnergy), .peakValid(peakValid),
    .peakSign(peakSign), .peakLoc(peakLoc), .txEnable(txEnable), .txAmpHigh(txAmpHigh),
    .quietHold(quietHold), .forcedLink(forcedLink), .tapStart(tapStart), .tapEnd(tapEnd)
  );

  // {preCode, postCode, duration, amp, expPreClk, expTxClk, expPostClk}
  // one microsecond = 2 clocks, one millisecond = 3 microseconds
  localparam int unsigned VEC [5][7] = '{
    '{0, 0, 0,  0, 1,    1,  1},
    '{1, 0, 5,  1, 60,   10, 1},
    '{0, 1, 1,  0, 1,    2,  60},
    '{2, 3, 7,  1, 600,  14, 6000},
    '{3, 2, 20, 0, 6000, 40, 600}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic wait_for(input int which);
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (which == 0 && quietHold) break;
      if (which == 1 && txEnable) break;
      if (which == 2 && !txEnable) break;
      if (which == 3 && forcedLink) break;
    end
  endtask

  task automatic run_seq(input bit expAmp, output int preN, output int txN, output int postN,
                         output bit ampBad, output logic [15:0] ctrlWr, output logic [15:0] ctrlPre);
    preN = 0; txN = 0; postN = 0; ampBad = 0; ctrlPre = 16'hFFFF;
    wr(3'd0, 16'h8000);
    rd(3'd0, ctrlWr);
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (txEnable) begin
        txN++;
        if (txAmpHigh !== expAmp) ampBad = 1;
      end else if (quietHold) begin
        if (txN == 0) begin
          if (preN == 0) rd(3'd0, ctrlPre);
          preN++;
        end else postN++;
      end else if (forcedLink) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, cw, cp;
    int pn, tn, qn;
    bit ab, sawTx;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, d); chk("R1 ctrl", d, 16'h0000);
    rd(3'd1, d); chk("R1 setup", d, 16'h0000);
    rd(3'd2, d); chk("R1 duration", d, 16'd16000);
    rd(3'd3, d); chk("R1 taps", d, 16'h2404);
    rd(3'd4, d); chk("R1 result", d, 16'h0000);
    chk("R1 outputs", {txEnable, quietHold, forcedLink}, 3'b000);
    chk("R1 tap outs", {tapEnd, tapStart}, {7'd36, 7'd4});

    // table of phase lengths (R3 R4 R5 R6 R2)
    for (int v = 0; v < 5; v++) begin
      wr(3'd1, 16'((VEC[v][3] << 12) | (VEC[v][1] << 2) | VEC[v][0]));
      wr(3'd2, 16'(VEC[v][2]));
      run_seq(VEC[v][3][0], pn, tn, qn, ab, cw, cp);
      chk("R2 start bit pending", {16'd0, cw[15]}, 1);
      chk("R2 cleared at run start", cp, 16'h0000);
      chk("R3 leading silence clocks", pn, VEC[v][4]);
      chk("R4 transmit clocks", tn, VEC[v][5]);
      chk("R4 drive level", ab, 0);
      chk("R5 trailing silence clocks", qn, VEC[v][6]);
      rd(3'd0, d); chk("R6 done no fail", d, 16'h0002);
      chk("R6 forced link", forcedLink, 1);
    end

    // R8 capture latest-wins, R9 start mid-run ignored, R7 energy outside pre ignored
    wr(3'd1, 16'h0000);
    wr(3'd2, 16'd10);
    wr(3'd0, 16'h8000);
    wait_for(1);
    peakValid = 1'b1; peakSign = 1'b1; peakLoc = 10'h155; lineEnergy = 1'b1;
    @(negedge clk);
    peakSign = 1'b0; peakLoc = 10'h0AA;
    @(negedge clk);
    peakValid = 1'b0;
    wr(3'd0, 16'h8000);
    wait_for(3);
    lineEnergy = 1'b0;
    rd(3'd0, d); chk("R9 start ignored, R7 no fail", d, 16'h0002);
    rd(3'd4, d); chk("R8 latest peak", d, 16'h08AA);
    @(negedge clk);
    peakValid = 1'b1; peakSign = 1'b1; peakLoc = 10'h3FF;
    @(negedge clk);
    peakValid = 1'b0;
    rd(3'd4, d); chk("R8 ignored in link", d, 16'h08AA);
    repeat (30) @(negedge clk);
    chk("R9 no second run", {txEnable, quietHold, forcedLink}, 3'b001);

    // R7 energy on the last leading-silence clock (60 clocks)
    wr(3'd1, 16'h0001);
    wr(3'd2, 16'd4);
    wr(3'd0, 16'h8000);
    wait_for(0);
    repeat (59) @(negedge clk);
    lineEnergy = 1'b1;
    @(negedge clk);
    lineEnergy = 1'b0;
    sawTx = txEnable;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (txEnable) sawTx = 1;
    end
    chk("R7 no transmit after abort", sawTx, 0);
    rd(3'd0, d); chk("R7 done and fail", d, 16'h0003);
    chk("R7 idle outputs", {quietHold, forcedLink}, 2'b00);

    // R8 clear on start and capture on the single trailing-silence clock
    wr(3'd1, 16'h0000);
    wr(3'd2, 16'd2);
    wr(3'd0, 16'h8000);
    wait_for(0);
    rd(3'd4, d); chk("R8 cleared at start", d, 16'h0000);
    wait_for(1);
    wait_for(2);
    chk("R5 in trailing silence", quietHold, 1);
    peakValid = 1'b1; peakSign = 1'b0; peakLoc = 10'h201;
    @(negedge clk);
    peakSign = 1'b1; peakLoc = 10'h01F;
    @(negedge clk);
    peakValid = 1'b0;
    rd(3'd4, d); chk("R8 capture at phase edge", d, 16'h0A01);
    chk("R6 link after collision", forcedLink, 1);

    // R10 taps
    wr(3'd3, 16'hAA95);
    rd(3'd3, d); chk("R10 taps readback", d, 16'h2A15);
    chk("R10 tap outputs", {tapEnd, tapStart}, {7'h2A, 7'h15});

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule